// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. Each enabled clock takes two 16-bit fractional operands, forms their product and adds it to a 36-bit accumulator. The accumulator holds a 4-bit extension field above a 16-bit high word and a 16-bit low word. The product goes into the accumulator in a single cycle.

A mode input picks how the second operand is read. In mode 0 both operands are two's-complement fractions, so $8000 means -1.0. In mode 1 the first operand stays signed and the second is read as an unsigned fraction, so $8000 means +1.0. Mode 1 is the building block for multi-precision multiplies. The unsigned low half of a wide operand can be multiplied by a signed word and summed into a running result. The extension bits absorb growth beyond the 32-bit range.

A synchronous reset clears the accumulator. A load input presets it to any 36-bit value. Instruction decode, rounding, saturation on readout and condition flags are handled elsewhere.

Top module: `mac_mixed_unit`

## Requirements
- R1: A high `rst` at a rising clock edge clears all 36 accumulator bits. It takes priority over `load` and `en`.
- R2: With `rst` low and `load` high, the accumulator takes `load_val` at the next edge, whatever `en` is.
- R3: With `rst`, `load` and `en` all low, the accumulator keeps its value.
- R4: With `mode` = 0 and `en` high, the addend is 2·A·B, with both A and B read as 16-bit two's complement.
- R5: With `mode` = 1 and `en` high, A is read as two's complement and B as unsigned (0 to 65535), so B = $8000 adds exactly +A·2^16.
- R6: The product is shifted left by one bit for fractional alignment. It is then sign-extended to 36 bits from the product's sign, which in mode 1 is A's sign. A = $8000, B = $8000 in mode 0 adds +$0:8000:0000.
- R7: The addition wraps modulo 2^36, with no saturation.
- R8: The accumulator appears on three outputs: bits 35..32 on `acc_ext`, bits 31..16 on `acc_hi` and bits 15..0 on `acc_lo`.
- R9: From $0:0000:0099 with A = $3456 and B = $8000, mode 1 gives $0:3456:0099 and mode 0 gives $F:CBAA:0099.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of the accumulator |
| en | input | 1 | Accumulate A·B on this edge |
| mode | input | 1 | 0: signed × signed, 1: signed × unsigned |
| load | input | 1 | Preset the accumulator from `load_val` |
| load_val | input | 36 | Preset value |
| op_a | input | 16 | First operand, always signed |
| op_b | input | 16 | Second operand, signedness set by `mode` |
| acc_ext | output | 4 | Accumulator bits 35..32 |
| acc_hi | output | 16 | Accumulator bits 31..16 |
| acc_lo | output | 16 | Accumulator bits 15..0 |

## Verification
The bench checks B = $8000 in both modes. A design that sign-extends B in mode 1 subtracts A·2^16 where it should add it. It also checks A = B = $8000 in mode 0, the one product that needs bit 31. A design that keeps only 32 product bits, or extends from the wrong bit, returns $F:8000:0000 instead of $0:8000:0000. Presets near ±2^35 catch a design that saturates or drops the carry into the extension field. Load-with-enable and idle cycles catch a design with the wrong priority or a spurious update. Random operands in both modes are compared against a wide-integer reference.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned MAC_OP_W  = 16;
    localparam int unsigned MAC_EXT_W = 4;

    typedef enum logic {
        MODE_SS = 1'b0,
        MODE_SU = 1'b1
    } mac_mode_e;

endpackage

// File: rtl/mac_opnd_ext.sv
module mac_opnd_ext #(
    parameter int unsigned W = 16
) (
    input  logic               as_unsigned,
    input  logic [W-1:0]       raw,
    output logic signed [W:0]  widened
);
    // One extra bit lets a single signed multiplier cover both readings.
    always_comb begin
        if (as_unsigned) widened = {1'b0, raw};
        else             widened = {raw[W-1], raw};
    end
endmodule

// File: rtl/mac_frac_mul.sv
module mac_frac_mul #(
    parameter int unsigned W     = 16,
    parameter int unsigned ACC_W = 36
) (
    input  logic signed [W:0]   fa,
    input  logic signed [W:0]   fb,
    output logic [ACC_W-1:0]    aligned
);
    localparam int unsigned PW = 2 * W + 2;
    localparam int SX = int'(ACC_W) - int'(2 * W) - 2;

    logic signed [PW-1:0] prod;

    assign prod = fa * fb;

    // Meaningful product lies in bits 2W..0; shift one left and extend.
    generate
        if (SX > 0) begin : g_extend
            assign aligned = {{SX{prod[PW-1]}}, prod[2*W:0], 1'b0};
        end else begin : g_trim
            logic unused_hi;
            assign unused_hi = prod[PW-1];
            assign aligned   = {prod[ACC_W-2:0], 1'b0};
        end
    endgenerate
endmodule

// File: rtl/mac_acc_add.sv
module mac_acc_add #(
    parameter int unsigned ACC_W = 36
) (
    input  logic [ACC_W-1:0] cur,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] sum
);
    // Plain modular sum: carry out of the top bit is discarded.
    assign sum = cur + addend;
endmodule

// File: rtl/mac_mixed_unit.sv
module mac_mixed_unit #(
    parameter int unsigned OP_W  = mac_pkg::MAC_OP_W,
    parameter int unsigned EXT_W = mac_pkg::MAC_EXT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        mode,
    input  logic                        load,
    input  logic [EXT_W+2*OP_W-1:0]     load_val,
    input  logic [OP_W-1:0]             op_a,
    input  logic [OP_W-1:0]             op_b,
    output logic [EXT_W-1:0]            acc_ext,
    output logic [OP_W-1:0]             acc_hi,
    output logic [OP_W-1:0]             acc_lo
);
    import mac_pkg::*;

    localparam int unsigned ACC_W = EXT_W + 2 * OP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic signed [OP_W:0] a_wide, b_wide;
    logic [ACC_W-1:0]     prod_aligned;
    logic [ACC_W-1:0]     acc_sum;
    logic                 b_unsigned;

    assign b_unsigned = (mac_mode_e'(mode) == MODE_SU);

    mac_opnd_ext #(.W(OP_W)) u_ext_a (
        .as_unsigned (1'b0),
        .raw         (op_a),
        .widened     (a_wide)
    );

    mac_opnd_ext #(.W(OP_W)) u_ext_b (
        .as_unsigned (b_unsigned),
        .raw         (op_b),
        .widened     (b_wide)
    );

    mac_frac_mul #(.W(OP_W), .ACC_W(ACC_W)) u_mul (
        .fa      (a_wide),
        .fb      (b_wide),
        .aligned (prod_aligned)
    );

    mac_acc_add #(.ACC_W(ACC_W)) u_add (
        .cur    (st_q.acc),
        .addend (prod_aligned),
        .sum    (acc_sum)
    );

    always_comb begin
        st_d = st_q;
        if (load)    st_d.acc = load_val;
        else if (en) st_d.acc = acc_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_ext = st_q.acc[ACC_W-1 -: EXT_W];
    assign acc_hi  = st_q.acc[2*OP_W-1 -: OP_W];
    assign acc_lo  = st_q.acc[OP_W-1:0];
endmodule

// File: rtl/mac_mixed_chk.sv
module mac_mixed_chk #(
    parameter int unsigned OP_W  = 16,
    parameter int unsigned EXT_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic                     mode,
    input logic                     load,
    input logic [EXT_W+2*OP_W-1:0]  load_val,
    input logic [OP_W-1:0]          op_a,
    input logic [OP_W-1:0]          op_b,
    input logic [EXT_W-1:0]         acc_ext,
    input logic [OP_W-1:0]          acc_hi,
    input logic [OP_W-1:0]          acc_lo
);
    localparam int unsigned ACC_W = EXT_W + 2 * OP_W;
    localparam logic [OP_W-1:0] HALF_SCALE = {1'b1, {(OP_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_all;
    logic [ACC_W-1:0] a_scaled;

    assign acc_all  = {acc_ext, acc_hi, acc_lo};
    assign a_scaled = {{EXT_W{op_a[OP_W-1]}}, op_a, {OP_W{1'b0}}};

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> acc_all == '0);

    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> acc_all == $past(load_val));

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(acc_all));

    p_minus_one_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && en && !mode && op_b == HALF_SCALE)
        |=> acc_all == $past(acc_all) - $past(a_scaled));

    p_plus_one_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && en && mode && op_b == HALF_SCALE)
        |=> acc_all == $past(acc_all) + $past(a_scaled));

    p_zero_operand_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && en && (op_a == '0 || op_b == '0)) |=> $stable(acc_all));
endmodule

bind mac_mixed_unit mac_mixed_chk #(.OP_W(OP_W), .EXT_W(EXT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .mode     (mode),
    .load     (load),
    .load_val (load_val),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc_ext  (acc_ext),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/sim_mac_mixed_unit.sv
module sim_mac_mixed_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 600;

    logic        clk = 1'b0;
    logic        rst, en, mode, load;
    logic [35:0] load_val;
    logic [15:0] op_a, op_b;
    logic [3:0]  acc_ext;
    logic [15:0] acc_hi, acc_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [35:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_mixed_unit u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .load(load),
        .load_val(load_val), .op_a(op_a), .op_b(op_b),
        .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    function automatic logic [35:0] ref_addend(logic [15:0] a, logic [15:0] b, logic m);
        longint sa, sb, p;
        sa = longint'($signed(a));
        sb = m ? longint'({48'd0, b}) : longint'($signed(b));
        p  = sa * sb * 2;
        return p[35:0];
    endfunction

    task automatic check(string req, logic [35:0] exp);
        logic [35:0] got;
        got = {acc_ext, acc_hi, acc_lo};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h:%h:%h expected %h:%h:%h", req,
                     got[35:32], got[31:16], got[15:0],
                     exp[35:32], exp[31:16], exp[15:0]);
        end
    endtask

    // Drive at the falling edge, sample one time unit after the rising edge.
    task automatic cyc(logic r, logic ld, logic [35:0] lv, logic e, logic m,
                       logic [15:0] a, logic [15:0] b);
        @(negedge clk);
        rst = r; load = ld; load_val = lv; en = e; mode = m; op_a = a; op_b = b;
        if (r)       model = '0;
        else if (ld) model = lv;
        else if (e)  model = model + ref_addend(a, b, m);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; load = 1'b0; load_val = '0; en = 1'b0; mode = 1'b0;
        op_a = '0; op_b = '0; model = '0;

        // R1: reset clears even with load and enable asserted
        cyc(1, 1, 36'hA_BCDE_F012, 1, 1, 16'h7FFF, 16'hFFFF);
        check("R1 reset", 36'h0);

        // R9 / R5: mixed-mode example
        cyc(0, 1, 36'h0_0000_0099, 0, 0, 0, 0);
        check("R2 preset", 36'h0_0000_0099);
        cyc(0, 0, 0, 1, 1, 16'h3456, 16'h8000);
        check("R9 R5 mixed example", 36'h0_3456_0099);

        // R9 / R4: signed example
        cyc(0, 1, 36'h0_0000_0099, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h3456, 16'h8000);
        check("R9 R4 signed example", 36'h F_CBAA_0099);

        // R8: field split
        cyc(0, 1, 36'h5_1234_ABCD, 0, 0, 0, 0);
        n_tests++;
        if (acc_ext !== 4'h5 || acc_hi !== 16'h1234 || acc_lo !== 16'hABCD) begin
            n_fail++;
            $display("FAIL R8 fields: got %h %h %h expected 5 1234 abcd", acc_ext, acc_hi, acc_lo);
        end

        // R3: idle cycles hold, operands toggling
        cyc(0, 0, 36'hF_FFFF_FFFF, 0, 1, 16'h7FFF, 16'h7FFF);
        cyc(0, 0, 36'h0, 0, 0, 16'h8000, 16'h8000);
        check("R3 idle hold", 36'h5_1234_ABCD);

        // R2: load wins over enable
        cyc(0, 1, 36'h3_0000_0001, 1, 1, 16'h7FFF, 16'hFFFF);
        check("R2 load priority", 36'h3_0000_0001);

        // R6: -1.0 x -1.0 in signed mode is +1.0
        cyc(0, 1, 36'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 16'h8000, 16'h8000);
        check("R6 minus one squared", 36'h0_8000_0000);

        // R6: negative A, largest unsigned B; extension from A's sign
        cyc(0, 1, 36'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'hFFFF, 16'hFFFF);
        check("R6 neg times unsigned max", 36'hF_FFFE_0002);

        // R5: largest positive product in mixed mode
        cyc(0, 1, 36'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h7FFF, 16'hFFFF);
        check("R5 positive max", 36'h0_FFFD_0002);

        // R7: wrap past the top of the range
        cyc(0, 1, 36'h7_FFFF_FFFF, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h0001, 16'h8000);
        check("R7 wrap positive", 36'h8_0000_FFFF);
        cyc(0, 1, 36'hF_FFFF_0000, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 16'h0001, 16'h8000);
        check("R7 wrap through zero", 36'h0_0000_0000);

        // R4 R5: random operands, both modes, random enables and presets
        for (int i = 0; i < N_RAND; i++) begin
            logic [15:0] ra, rb;
            logic rm, re, rl;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rm = 1'($urandom);
            re = ($urandom % 8) != 0;
            rl = ($urandom % 50) == 0;
            if ((i % 37) == 5) ra = 16'h8000;
            if ((i % 41) == 7) rb = 16'h8000;
            cyc(0, rl, {4'($urandom), 32'($urandom)}, re, rm, ra, rb);
            check(rm ? "R5 random mixed" : "R4 random signed", model);
        end

        // R1: reset mid-run
        cyc(1, 0, 0, 1, 0, 16'h1234, 16'h5678);
        check("R1 reset mid-run", 36'h0);

        finish_run();
    end
endmodule